// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block sits between a CPU and a shared card bus and turns a 23-bit CPU word address into a 22-bit physical word address. Four 24-bit segment registers hold relocation bases. The CPU loads them through a small write window: each register is reached through two offsets, one for its upper byte and one for its lower half-word.

The top bit of the CPU address picks the mode. When it is set, the segment named by the next two address bits supplies the base. When it is clear, translation is bypassed and a fixed boot base is used instead. Two fixed bases exist, chosen by a from-reset flag. A boot-reset pulse sets that flag, and an init-register write loads it. This lets start-up code run from a relocated window until it releases it.

The sum of the address and the scaled base keeps 21 bits. Its bit 20 is copied into output bit 21, so physical space appears as two mirrored halves. The translation path is combinational.

Top module: `sat_top`

## Requirements
- R1: While `rst_n` is low, all four segment registers clear to zero and the from-reset flag is set.
- R2: A register write selects segment register `reg_off[2:1]` (0 to 3). A cycle with `reg_we` low changes no register.
- R3: A write with `reg_off[0]`=1 replaces register bits [15:0] with `reg_data` and keeps bits [23:16].
- R4: A write with `reg_off[0]`=0 loads `reg_data[7:0]` into register bits [23:16] and keeps bits [15:0]. `reg_data[15:8]` is ignored.
- R5: When `cpu_addr[22]`=1, the base is segment register `cpu_addr[21:20]`.
- R6: When `cpu_addr[22]`=0, the base is 0xFFFE00 while the from-reset flag is set and 0xFFF000 while it is clear.
- R7: With S = (`cpu_addr[20:0]` + base[11:0]·512) mod 2^21, the output `phys_addr` equals {S[20], S}. Base bits [23:12] have no effect.
- R8: A cycle with `boot_rst` high sets the from-reset flag from the next cycle on.
- R9: A cycle with `init_we` high and `boot_rst` low loads the flag from `init_bit`. When both are high, `boot_rst` wins. With neither high, the flag holds.
- R10: `phys_addr` follows `cpu_addr` in the same cycle. A register or flag update shows at `phys_addr` from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 23 | CPU word address |
| reg_we | input | 1 | Segment register write strobe |
| reg_off | input | 3 | Register window offset: [2:1] register, [0] half |
| reg_data | input | 16 | Segment register write data |
| boot_rst | input | 1 | Boot-reset pulse, sets the from-reset flag |
| init_we | input | 1 | Init register write strobe |
| init_bit | input | 1 | Init write data bit 0, new from-reset flag value |
| phys_addr | output | 22 | Physical word address on the card bus |

## Verification
The hardest case to reach is a carry out of the scaled base add that crosses bit 20. That carry flips both mirrored top bits at once, and it can wrap past bit 21 as well. It needs a large segment base together with an address near the top of a half.

The stimulus loads each segment with bases near 0xFFF and 0x800. It then sweeps word addresses spread across the whole 2^21 range, including values just below and above 0x100000 and 0x1FFFFF. Every result is compared with an arithmetic model.

The bypass bases are reached by sequencing init writes and boot-reset pulses, including the cycle in which both arrive together.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic {
    XL_BYPASS  = 1'b0,
    XL_SEGMENT = 1'b1
  } xl_mode_e;

  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } reg_half_e;
endpackage

// File: rtl/sat_seg_regs.sv
module sat_seg_regs
  import sat_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int SEG_W   = 24,
  parameter int UPPER_W = 8,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 12,
  parameter int IDX_W   = $clog2(NSEG),
  parameter int OFF_W   = IDX_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [OFF_W-1:0]                wr_off,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NSEG-1:0][FIELD_W-1:0]    base_field
);
  localparam int LOWER_W = SEG_W - UPPER_W;

  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [NSEG-1:0]            wr_lo;
  logic [NSEG-1:0]            wr_hi;
  logic [IDX_W-1:0]           wr_idx;
  reg_half_e                  wr_half;

  assign wr_idx  = wr_off[OFF_W-1:1];
  assign wr_half = reg_half_e'(wr_off[0]);

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign wr_lo[i] = wr_en && (wr_idx == IDX_W'(i)) && (wr_half == HALF_LOWER);
    assign wr_hi[i] = wr_en && (wr_idx == IDX_W'(i)) && (wr_half == HALF_UPPER);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[i] <= '0;
      end else if (wr_lo[i]) begin
        seg_q[i][LOWER_W-1:0] <= wr_data[LOWER_W-1:0];
      end else if (wr_hi[i]) begin
        seg_q[i][SEG_W-1:LOWER_W] <= wr_data[UPPER_W-1:0];
      end
    end

    assign base_field[i] = seg_q[i][FIELD_W-1:0];

    // R3
    lower_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo[i] |=> (seg_q[i][LOWER_W-1:0] == $past(wr_data[LOWER_W-1:0]))
                && (seg_q[i][SEG_W-1:LOWER_W] == $past(seg_q[i][SEG_W-1:LOWER_W])));

    // R4
    upper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi[i] |=> (seg_q[i][SEG_W-1:LOWER_W] == $past(wr_data[UPPER_W-1:0]))
                && (seg_q[i][LOWER_W-1:0] == $past(seg_q[i][LOWER_W-1:0])));

    // R2
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_lo[i] || wr_hi[i]) |=> $stable(seg_q[i]));
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi}));
endmodule

// File: rtl/sat_boot_ctl.sv
module sat_boot_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_rst,
  input  logic init_we,
  input  logic init_bit,
  output logic from_reset
);
  logic load_init;

  assign load_init = init_we && !boot_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      from_reset <= 1'b1;
    end else if (boot_rst) begin
      from_reset <= 1'b1;
    end else if (load_init) begin
      from_reset <= init_bit;
    end
  end

  // R8
  boot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_rst |=> from_reset);

  // R9
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_we && !boot_rst) |=> (from_reset == $past(init_bit)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_we && !boot_rst) |=> $stable(from_reset));
endmodule

// File: rtl/sat_xlate.sv
module sat_xlate
  import sat_pkg::*;
#(
  parameter int          NSEG      = 4,
  parameter int          VA_W      = 23,
  parameter int          PA_W      = 22,
  parameter int          FIELD_W   = 12,
  parameter int          GRAN      = 9,
  parameter logic [11:0] BOOT_BASE = 12'hE00,
  parameter logic [11:0] RUN_BASE  = 12'h000,
  parameter int          IDX_W     = $clog2(NSEG)
) (
  input  logic [VA_W-1:0]              va,
  input  logic [NSEG-1:0][FIELD_W-1:0] base_field,
  input  logic                         from_reset,
  output xl_mode_e                     mode,
  output logic [FIELD_W-1:0]           sel_base,
  output logic [PA_W-1:0]              pa
);
  localparam int SUM_W = PA_W - 1;

  function automatic logic [SUM_W-1:0] f_addend(input logic [FIELD_W-1:0] b);
    logic [SUM_W-1:0] w;
    w = SUM_W'(b);
    return w << GRAN;
  endfunction

  function automatic logic [PA_W-1:0] f_fold(input logic [SUM_W-1:0] s);
    return {s[SUM_W-1], s};
  endfunction

  logic [IDX_W-1:0] seg_idx;
  logic [SUM_W-1:0] sum;

  assign mode    = xl_mode_e'(va[VA_W-1]);
  assign seg_idx = va[VA_W-2 -: IDX_W];

  always_comb begin
    if (mode == XL_SEGMENT) sel_base = base_field[seg_idx];
    else if (from_reset)    sel_base = BOOT_BASE[FIELD_W-1:0];
    else                    sel_base = RUN_BASE[FIELD_W-1:0];
  end

  assign sum = va[SUM_W-1:0] + f_addend(sel_base);
  assign pa  = f_fold(sum);
endmodule

// File: rtl/sat_top.sv
module sat_top
  import sat_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int SEG_W   = 24,
  parameter int UPPER_W = 8,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 12,
  parameter int GRAN    = 9,
  parameter int VA_W    = 23,
  parameter int PA_W    = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [VA_W-1:0]         cpu_addr,
  input  logic                    reg_we,
  input  logic [$clog2(NSEG):0]   reg_off,
  input  logic [DATA_W-1:0]       reg_data,
  input  logic                    boot_rst,
  input  logic                    init_we,
  input  logic                    init_bit,
  output logic [PA_W-1:0]         phys_addr
);
  localparam int IDX_W = $clog2(NSEG);
  localparam int OFF_W = IDX_W + 1;
  localparam int SUM_W = PA_W - 1;

  logic [NSEG-1:0][FIELD_W-1:0] base_field;
  logic                         from_reset;
  xl_mode_e                     mode;
  logic [FIELD_W-1:0]           sel_base;

  sat_seg_regs #(
    .NSEG(NSEG), .SEG_W(SEG_W), .UPPER_W(UPPER_W), .DATA_W(DATA_W),
    .FIELD_W(FIELD_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_off(reg_off),
    .wr_data(reg_data), .base_field(base_field)
  );

  sat_boot_ctl u_boot (
    .clk(clk), .rst_n(rst_n), .boot_rst(boot_rst), .init_we(init_we),
    .init_bit(init_bit), .from_reset(from_reset)
  );

  sat_xlate #(
    .NSEG(NSEG), .VA_W(VA_W), .PA_W(PA_W), .FIELD_W(FIELD_W), .GRAN(GRAN),
    .IDX_W(IDX_W)
  ) u_xl (
    .va(cpu_addr), .base_field(base_field), .from_reset(from_reset),
    .mode(mode), .sel_base(sel_base), .pa(phys_addr)
  );

  // R6
  bypass_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XL_BYPASS && !from_reset) |-> (phys_addr[SUM_W-1:0] == cpu_addr[SUM_W-1:0]));

  // R6
  bypass_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XL_BYPASS) |-> (sel_base == (from_reset ? FIELD_W'(12'hE00) : FIELD_W'(0))));

  // R7
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[PA_W-1] == phys_addr[PA_W-2]);
endmodule

// File: tb/sim_sat_top.sv
`timescale 1ns/1ps
module sim_sat_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] cpu_addr = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [15:0] reg_data = '0;
  logic        boot_rst = 1'b0;
  logic        init_we = 1'b0;
  logic        init_bit = 1'b0;
  logic [21:0] phys_addr;

  int total = 0;
  int bad = 0;

  logic [23:0] mseg [4];
  bit          mflag;

  always #2.5 clk = ~clk;

  sat_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .reg_we(reg_we),
    .reg_off(reg_off), .reg_data(reg_data), .boot_rst(boot_rst),
    .init_we(init_we), .init_bit(init_bit), .phys_addr(phys_addr)
  );

  function automatic logic [21:0] model(input logic [22:0] a);
    int unsigned base, s, lo;
    if (a[22]) base = int'(mseg[a[21:20]]);
    else       base = mflag ? 32'hFFFE00 : 32'hFFF000;
    lo = int'(a) % 2097152;
    s  = (lo + (base % 4096) * 512) % 2097152;
    return 22'(s + ((s / 1048576) % 2) * 2097152);
  endfunction

  task automatic chk(input string rq, input logic [22:0] a);
    logic [21:0] e;
    cpu_addr = a;
    #0.2;
    e = model(a);
    total++;
    if (phys_addr !== e) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", rq, a, phys_addr, e);
    end
  endtask

  task automatic wr_reg(input logic [2:0] off, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_off = off; reg_data = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (off[0]) mseg[off[2:1]][15:0]  = d;
    else        mseg[off[2:1]][23:16] = d[7:0];
  endtask

  task automatic wr_init(input logic b, input logic rs);
    @(negedge clk);
    init_we = 1'b1; init_bit = b; boot_rst = rs;
    @(negedge clk);
    init_we = 1'b0; boot_rst = 1'b0;
    mflag = rs ? 1'b1 : b;
  endtask

  task automatic sweep(input string rq, input logic top, input logic [1:0] sg);
    for (int k = 0; k < 64; k++) begin
      chk(rq, {top, sg, 20'h0} | 23'((k * 32768 + (k * 37) % 512) % 2097152));
    end
    chk(rq, {top, sg, 20'h0} | 23'h0FFFFF);
    chk(rq, {top, sg, 20'h0} | 23'h100000);
    chk(rq, {top, sg, 20'h0} | 23'h1FFFFF);
    chk(rq, {top, sg, 20'h0} | 23'h0FFE00);
    chk(rq, {top, sg, 20'h0} | 23'h1001FF);
  endtask

  initial begin
    #(200000 * 5.0);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mseg[i] = '0;
    mflag = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state: boot base, zero segments
    chk("R1", 23'h000000);
    total++;
    if (phys_addr !== 22'h3C0000) begin
      bad++;
      $display("FAIL R1 actual=%h expected=%h", phys_addr, 22'h3C0000);
    end
    chk("R1", 23'h400000);
    chk("R1", 23'h7FFFFF);
    sweep("R6", 1'b0, 2'd0);

    // R2 strobe low: no change
    @(negedge clk);
    reg_off = 3'd3; reg_data = 16'hFFFF;
    @(negedge clk);
    sweep("R2", 1'b1, 2'd1);

    // R3 R4 R5 R7 each segment, several bases
    for (int s = 0; s < 4; s++) begin
      wr_reg(3'(s * 2 + 1), 16'h0FFF - 16'(s));
      chk("R10", {1'b1, 2'(s), 20'h00100});
      sweep("R3", 1'b1, 2'(s));
      wr_reg(3'(s * 2), 16'hA5C3 + 16'(s));
      sweep("R4", 1'b1, 2'(s));
      wr_reg(3'(s * 2 + 1), 16'h7800 + 16'(s * 256));
      sweep("R7", 1'b1, 2'(s));
    end
    for (int s = 0; s < 4; s++) sweep("R5", 1'b1, 2'(s));
    sweep("R2", 1'b1, 2'd2);

    // R9 init clears flag, R6 run base
    wr_init(1'b0, 1'b0);
    sweep("R9", 1'b0, 2'd1);
    sweep("R6", 1'b0, 2'd3);
    wr_init(1'b1, 1'b0);
    sweep("R9", 1'b0, 2'd2);
    wr_init(1'b0, 1'b0);
    chk("R9", 23'h000123);

    // R8 boot pulse
    @(negedge clk);
    boot_rst = 1'b1;
    @(negedge clk);
    boot_rst = 1'b0;
    mflag = 1'b1;
    sweep("R8", 1'b0, 2'd0);

    // R9 both together: boot wins
    wr_init(1'b0, 1'b0);
    chk("R9", 23'h010000);
    wr_init(1'b0, 1'b1);
    sweep("R9", 1'b0, 2'd1);

    // R1 reset again clears segments
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) mseg[i] = '0;
    mflag = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1", 1'b1, 2'd3);
    sweep("R1", 1'b0, 2'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule